// File: doc/BRIEF.md
# Load/Store-Multiple Address Sequencer

This block expands one block-transfer command into a run of word memory requests. A command carries a 16-bit register-select mask, a 32-bit base address, a mode bit that picks increment-after or decrement-before addressing, a direction bit (load or store) and a writeback flag. The sequencer counts the set bits of the mask when it accepts the command. It therefore knows the final base value before the first access.

Each selected register then gets one request, issued in ascending register-index order. A request carries the register index, a word address and the direction, and is held on a valid/ready handshake until the memory side accepts it. For loads, the memory side returns the read word during the accepting cycle. If that word is destined for register 15, which is the program counter, the sequencer checks bit 0. When bit 0 is set it signals a branch to the word with bit 0 cleared; when bit 0 is clear it raises a fault instead.

One cycle after the last accepted request, the block pulses a completion strobe. When writeback was requested it also presents the updated base value.

Top module: `lsm_addr_seq`

## Requirements
- R1: A command is taken only while `cmd_ready` is high. `cmd_ready` is low from the cycle after acceptance until the final request has been accepted. A command offered while the block is busy has no effect on the running sequence.
- R2: With `cmd_mode` = 0 (increment-after) and n set mask bits, the requests go to base, base+4, …, base+4*(n-1). Each request goes to the next set register index in ascending order.
- R3: With `cmd_mode` = 1 (decrement-before), the requests go to base-4*n, base-4*n+4, …, base-4. The lowest set register index uses the lowest address.
- R4: An all-zero mask is answered with a one-cycle `cmd_err` pulse in the cycle after it is offered, and no request is issued.
- R5: While `req_valid` is high and `req_ready` is low, `req_reg`, `req_addr` and `req_write` stay unchanged and `req_valid` stays high.
- R6: `done` is high for exactly one cycle, the cycle after the last request is accepted.
- R7: When `cmd_wb` was 1, `wb_valid` is high together with `done`. `wb_data` then equals base+4*n in increment-after mode and base-4*n in decrement-before mode. When `cmd_wb` was 0, `wb_valid` stays low.
- R8: `req_write` is 1 on every request of a store command (`cmd_load` = 0) and 0 on every request of a load command. The address rules are the same for both directions.
- R9: On a load whose mask includes register 15, if the word returned for register 15 has bit 0 = 1, then `branch_valid` pulses together with `done` and `branch_target` equals that word with bit 0 cleared.
- R10: On such a load, if the returned word has bit 0 = 0, then `pc_fault` pulses together with `done` and `branch_valid` stays low.
- R11: A store command never raises `branch_valid` or `pc_fault`, even when register 15 is in the mask.
- R12: After reset the block is idle: `cmd_ready` high, and `req_valid`, `done`, `wb_valid`, `cmd_err`, `branch_valid` and `pc_fault` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_mask | input | 16 | Register-select mask, bit i selects register i |
| cmd_base | input | 32 | Base address |
| cmd_mode | input | 1 | 0 = increment-after, 1 = decrement-before |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_wb | input | 1 | Report the updated base at the end |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory side accepts the request |
| req_reg | output | 4 | Register index of the request |
| req_addr | output | 32 | Word address of the request |
| req_write | output | 1 | 1 = store request, 0 = load request |
| req_rdata | input | 32 | Read word, valid in the accepting cycle of a load |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Updated base is presented (with done) |
| wb_data | output | 32 | Updated base value |
| cmd_err | output | 1 | One-cycle pulse for a rejected empty mask |
| branch_valid | output | 1 | One-cycle branch request from a load of register 15 |
| branch_target | output | 32 | Branch address, bit 0 cleared |
| pc_fault | output | 1 | One-cycle pulse: register-15 word had bit 0 clear |

## Verification
Register 15 is always the highest index and so is always transferred last. Its branch or fault decision therefore lands in the same cycle as the completion pulse and, when writeback is requested, the updated base. The bench provokes this with load commands that select register 15 and have writeback on, in both modes and with both values of bit 0. It also runs a store that selects register 15. In that single completion cycle it samples `done`, `wb_valid`, `wb_data`, `branch_valid`, `branch_target` and `pc_fault` together and compares them against values it derives from the mask, base and mode. This exposes any design that lets one of these results slip by a cycle or suppress another.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int LSM_NREG = 16;
    localparam int LSM_AW   = 32;

    typedef enum logic {
        MODE_INC_AFTER  = 1'b0,
        MODE_DEC_BEFORE = 1'b1
    } lsm_mode_e;

endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_i,
    output logic [CW-1:0] count_o
);

    logic [CW-1:0] partial [W+1];

    assign partial[0] = '0;

    generate
        for (genvar g = 0; g < W; g++) begin : g_sum
            assign partial[g+1] = partial[g] + CW'(bits_i[g]);
        end
    endgenerate

    assign count_o = partial[W];

endmodule

// File: rtl/lsm_lowbit.sv
module lsm_lowbit #(
    parameter int W  = 16,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  mask_i,
    output logic [IW-1:0] idx_o,
    output logic          found_o
);

    always_comb begin
        idx_o   = '0;
        found_o = |mask_i;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq #(
    parameter int NREG = lsm_pkg::LSM_NREG,
    parameter int AW   = lsm_pkg::LSM_AW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [NREG-1:0]         cmd_mask,
    input  logic [AW-1:0]           cmd_base,
    input  logic                    cmd_mode,
    input  logic                    cmd_load,
    input  logic                    cmd_wb,
    output logic                    req_valid,
    input  logic                    req_ready,
    output logic [$clog2(NREG)-1:0] req_reg,
    output logic [AW-1:0]           req_addr,
    output logic                    req_write,
    input  logic [AW-1:0]           req_rdata,
    output logic                    done,
    output logic                    wb_valid,
    output logic [AW-1:0]           wb_data,
    output logic                    cmd_err,
    output logic                    branch_valid,
    output logic [AW-1:0]           branch_target,
    output logic                    pc_fault
);

    localparam int RW     = $clog2(NREG);
    localparam int CW     = $clog2(NREG + 1);
    localparam int PC_IDX = NREG - 1;
    localparam logic [AW-1:0] WORD_STEP = AW'(4);

    typedef struct packed {
        logic            busy;
        logic [NREG-1:0] pend;
        logic [AW-1:0]   addr;
        logic            load;
        logic            wb;
        logic [AW-1:0]   fin;
        logic            done;
        logic            wbv;
        logic            err;
        logic            br;
        logic            flt;
        logic [AW-1:0]   tgt;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [CW-1:0]   cmd_cnt;
    logic [AW-1:0]   span;
    logic [RW-1:0]   cur_idx;
    logic            cur_found;
    logic [NREG-1:0] cur_onehot;
    logic [NREG-1:0] rest_mask;
    logic            is_dec;

    lsm_popcount #(.W(NREG), .CW(CW)) u_count (
        .bits_i  (cmd_mask),
        .count_o (cmd_cnt)
    );

    lsm_lowbit #(.W(NREG), .IW(RW)) u_pick (
        .mask_i  (st_q.pend),
        .idx_o   (cur_idx),
        .found_o (cur_found)
    );

    assign span       = AW'(cmd_cnt) << 2;
    assign cur_onehot = NREG'(1) << cur_idx;
    assign rest_mask  = st_q.pend & ~cur_onehot;
    assign is_dec     = (lsm_pkg::lsm_mode_e'(cmd_mode) == lsm_pkg::MODE_DEC_BEFORE);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.wbv  = 1'b0;
        st_d.err  = 1'b0;
        st_d.br   = 1'b0;
        st_d.flt  = 1'b0;

        if (!st_q.busy) begin
            if (cmd_valid) begin
                if (cmd_mask == '0) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.busy = 1'b1;
                    st_d.pend = cmd_mask;
                    st_d.load = cmd_load;
                    st_d.wb   = cmd_wb;
                    st_d.addr = is_dec ? (cmd_base - span) : cmd_base;
                    st_d.fin  = is_dec ? (cmd_base - span) : (cmd_base + span);
                end
            end
        end else if (req_ready && cur_found) begin
            st_d.pend = rest_mask;
            st_d.addr = st_q.addr + WORD_STEP;
            if (rest_mask == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.wbv  = st_q.wb;
                if (st_q.load && (cur_idx == RW'(PC_IDX))) begin
                    if (req_rdata[0]) begin
                        st_d.br  = 1'b1;
                        st_d.tgt = {req_rdata[AW-1:1], 1'b0};
                    end else begin
                        st_d.flt = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_ready     = !st_q.busy;
    assign req_valid     = st_q.busy && cur_found;
    assign req_reg       = cur_idx;
    assign req_addr      = st_q.addr;
    assign req_write     = st_q.busy && !st_q.load;
    assign done          = st_q.done;
    assign wb_valid      = st_q.wbv;
    assign wb_data       = st_q.fin;
    assign cmd_err       = st_q.err;
    assign branch_valid  = st_q.br;
    assign branch_target = st_q.tgt;
    assign pc_fault      = st_q.flt;

    AST_HOLD_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_reg) && $stable(req_write))) else $error("request changed while stalled"); // R5

    AST_NO_CMD_WHILE_ISSUING: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !cmd_ready) else $error("command path open during sequence"); // R1

    AST_EMPTY_NO_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (!req_valid && !done)) else $error("empty mask produced activity"); // R4

    AST_BRANCH_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |-> (done && !pc_fault && !branch_target[0])) else $error("branch outside completion"); // R9

    AST_FAULT_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        pc_fault |-> (done && !branch_valid)) else $error("fault outside completion"); // R10

    AST_WB_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> done) else $error("writeback without completion"); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("completion longer than one cycle"); // R6

    AST_STORE_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (!branch_valid && !pc_fault)) else $error("store raised branch or fault"); // R11

endmodule

// File: tb/lsm_addr_seq_bench.sv
module lsm_addr_seq_bench;

    typedef struct packed {
        logic [15:0] mask;
        logic [31:0] base;
        logic        mode;
        logic        load;
        logic        wb;
        logic        stall;
        logic [31:0] pcval;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t TBL [NVEC] = '{
        '{16'h0001, 32'h0000_1000, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0},
        '{16'h00F0, 32'h0000_2000, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0},
        '{16'h8001, 32'h0000_0100, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_3001},
        '{16'h8000, 32'h0000_0400, 1'b1, 1'b1, 1'b0, 1'b1, 32'h0000_2000},
        '{16'hFFFF, 32'h0000_8000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0001},
        '{16'hA5A5, 32'h0000_0040, 1'b1, 1'b1, 1'b1, 1'b0, 32'hDEAD_BEEF},
        '{16'h0102, 32'h0000_0008, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0},
        '{16'h4000, 32'hFFFF_FFFC, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [15:0] cmd_mask = '0;
    logic [31:0] cmd_base = '0;
    logic        cmd_mode = 1'b0;
    logic        cmd_load = 1'b0;
    logic        cmd_wb = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [3:0]  req_reg;
    logic [31:0] req_addr;
    logic        req_write;
    logic [31:0] req_rdata = '0;
    logic        done;
    logic        wb_valid;
    logic [31:0] wb_data;
    logic        cmd_err;
    logic        branch_valid;
    logic [31:0] branch_target;
    logic        pc_fault;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    lsm_addr_seq u_lsm_addr_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_mask(cmd_mask),
        .cmd_base(cmd_base), .cmd_mode(cmd_mode), .cmd_load(cmd_load), .cmd_wb(cmd_wb),
        .req_valid(req_valid), .req_ready(req_ready), .req_reg(req_reg),
        .req_addr(req_addr), .req_write(req_write), .req_rdata(req_rdata),
        .done(done), .wb_valid(wb_valid), .wb_data(wb_data), .cmd_err(cmd_err),
        .branch_valid(branch_valid), .branch_target(branch_target), .pc_fault(pc_fault)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL R6 watchdog expired actual=%0d expected<100000", cycles);
            finish_run();
        end
    end

    task automatic run_cmd(input vec_t v, input bit intrude);
        int n;
        int k;
        logic [31:0] start;
        logic [31:0] exp_addr;
        logic [31:0] exp_wb;
        bit pc_sel;
        n = $countones(v.mask);
        start  = v.mode ? (v.base - 32'(4 * n)) : v.base;
        exp_wb = v.mode ? (v.base - 32'(4 * n)) : (v.base + 32'(4 * n));
        pc_sel = v.load && v.mask[15];
        @(negedge clk);
        chk("R1 cmd_ready when idle", 32'(cmd_ready), 32'd1);
        cmd_valid = 1'b1;
        cmd_mask  = v.mask;
        cmd_base  = v.base;
        cmd_mode  = v.mode;
        cmd_load  = v.load;
        cmd_wb    = v.wb;
        @(negedge clk);
        if (intrude) begin
            cmd_mask = 16'hFFFF;
            cmd_base = 32'h0;
            cmd_mode = ~v.mode;
            cmd_load = ~v.load;
        end else begin
            cmd_valid = 1'b0;
        end
        k = 0;
        for (int i = 0; i < 16; i++) begin
            if (v.mask[i]) begin
                exp_addr = start + 32'(4 * k);
                chk("R1 cmd_ready low while busy", 32'(cmd_ready), 32'd0);
                chk("R5 req_valid", 32'(req_valid), 32'd1);
                chk(v.mode ? "R3 register order" : "R2 register order", 32'(req_reg), 32'(i));
                chk(v.mode ? "R3 address" : "R2 address", req_addr, exp_addr);
                chk("R8 direction", 32'(req_write), 32'(!v.load));
                if (v.stall) begin
                    req_ready = 1'b0;
                    @(negedge clk);
                    chk("R5 held valid", 32'(req_valid), 32'd1);
                    chk("R5 held address", req_addr, exp_addr);
                    chk("R5 held register", 32'(req_reg), 32'(i));
                end
                req_rdata = (i == 15) ? v.pcval : 32'(i);
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                k++;
            end
        end
        cmd_valid = 1'b0;
        chk("R6 done after last request", 32'(done), 32'd1);
        chk("R6 no request at done", 32'(req_valid), 32'd0);
        chk("R7 wb_valid", 32'(wb_valid), 32'(v.wb));
        if (v.wb) chk("R7 wb_data", wb_data, exp_wb);
        chk(v.load ? "R9 branch_valid" : "R11 store branch_valid", 32'(branch_valid), 32'(pc_sel && v.pcval[0]));
        chk(v.load ? "R10 pc_fault" : "R11 store pc_fault", 32'(pc_fault), 32'(pc_sel && !v.pcval[0]));
        if (pc_sel && v.pcval[0]) chk("R9 branch_target", branch_target, {v.pcval[31:1], 1'b0});
        @(negedge clk);
        chk("R6 done is one cycle", 32'(done), 32'd0);
        chk("R1 idle after sequence", 32'(cmd_ready), 32'd1);
    endtask

    initial begin
        vec_t extra;
        repeat (3) @(negedge clk);
        chk("R12 reset cmd_ready", 32'(cmd_ready), 32'd1);
        chk("R12 reset req_valid", 32'(req_valid), 32'd0);
        chk("R12 reset pulses", {27'd0, done, wb_valid, cmd_err, branch_valid, pc_fault}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 idle after reset release", {30'd0, cmd_ready, req_valid}, 32'd2);

        for (int t = 0; t < NVEC; t++) begin
            run_cmd(TBL[t], 1'b0);
        end

        // R4: empty mask
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_mask  = 16'h0000;
        cmd_base  = 32'h0000_5000;
        cmd_load  = 1'b1;
        cmd_wb    = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R4 cmd_err pulse", 32'(cmd_err), 32'd1);
        chk("R4 no request", 32'(req_valid), 32'd0);
        chk("R4 no done", 32'(done), 32'd0);
        @(negedge clk);
        chk("R4 cmd_err one cycle", 32'(cmd_err), 32'd0);
        chk("R4 still no request", 32'(req_valid), 32'd0);

        // R1: command offered while busy is ignored
        extra = '{16'h8420, 32'h0000_0600, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0A11};
        run_cmd(extra, 1'b1);
        extra = '{16'h0C00, 32'h0000_0300, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0};
        run_cmd(extra, 1'b1);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule